// File: doc/BRIEF.md
# Clock Output Gate with Enable / Power-Down Control

This block sits between a generated clock and its output pad. One control pin decides whether the clock reaches the pad. When the output is off, the clock is held low and the pad driver is released. Two static configuration inputs set what the pin means and when a change on it takes effect. The first makes the pin either an active-high output enable or an active-low power-down. The second selects immediate (asynchronous) or clock-aligned (synchronous) switching.

In output-enable use, the oscillator and PLL keep running, so the clock comes back as soon as the pin allows it. In power-down use, the block asks the oscillator and PLL to go to standby. When the pin releases power-down, the block holds the output off while a relock timer runs, and it flags that wait on a status output. The timer stands in for the real PLL lock. In synchronous mode the pin is first passed through a two-flop synchronizer. Both switching off and switching on are then committed only while the clock is low, so every high phase that leaves the block is a whole one.

Top module: `clkout_ctl`

## Requirements
- R1: While `rst_n` is low, `clk_out`, `pad_oe`, `standby_req` and `relock_busy` are all 0, whatever the level of `ctl_pin`.
- R2: With `cfg_pd_mode`=0 (enable function), `ctl_pin`=1 lets the clock through and `ctl_pin`=0 stops it. In this function `standby_req` and `relock_busy` never assert, and the clock returns without any relock wait.
- R3: With `cfg_pd_mode`=1 (power-down function), `ctl_pin`=0 asserts `standby_req` and turns the output off.
- R4: Whenever `pad_oe` is 0, `clk_out` is 0. While the output is on, `pad_oe` is 1 and `clk_out` follows `src_clk`.
- R5: With `cfg_sync`=0, a change on `ctl_pin` reaches `pad_oe`, `clk_out` and `standby_req` without waiting for any clock edge. This holds even in the middle of a high phase, so truncated pulses are allowed.
- R6: With `cfg_sync`=1, a change on `ctl_pin` made while `src_clk` is low has no effect through the next two rising edges. It takes effect at the falling edge that follows them.
- R7: With `cfg_sync`=1, `pad_oe` changes only while `src_clk` is low. Every high pulse on `clk_out` lasts a full high phase of `src_clk`, including the first pulse after an enable.
- R8: When power-down is released, `relock_busy` is 1 and the output stays off for exactly `LOCK_CYCLES` rising edges of `src_clk`. The output then turns on. In synchronous mode it turns on at the next falling edge.
- R9: With `cfg_sync`=1 and `cfg_pd_mode`=1, `standby_req` rises at the same falling edge at which `pad_oe` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Generated clock to be gated; also clocks the block |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released away from clock edges |
| ctl_pin | input | 1 | Control pin: 1 = run, 0 = disable or power down |
| cfg_pd_mode | input | 1 | Pin function: 0 = output enable, 1 = power-down |
| cfg_sync | input | 1 | Switching timing: 0 = immediate, 1 = aligned to the clock |
| clk_out | output | 1 | Gated clock toward the pad, low when off |
| pad_oe | output | 1 | Pad driver enable; 0 = pad tristated |
| standby_req | output | 1 | Standby request to the oscillator and PLL |
| relock_busy | output | 1 | High while the relock wait after power-down runs |

## Verification
On every cycle, the assertions check four things. A released pad never carries a high clock. Standby and relock never appear in enable function. The relock wait keeps the output off and never outlasts its configured length. In synchronous mode the driver enable changes only while the clock is low. The bench scenarios are the only way to show the following: the exact edge on which a synchronous change commits, the immediate cut-off in the middle of a high phase in asynchronous mode, the full width of every pulse in synchronous mode, and the exact relock length.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic {
    PIN_ENABLE    = 1'b0,
    PIN_POWERDOWN = 1'b1
  } pin_fn_e;
endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic valid
);
  logic [STAGES-1:0] data_q, data_d;
  logic [STAGES-1:0] fill_q, fill_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        data_d = d;
        fill_d = 1'b1;
      end
    end else begin : g_many
      always_comb begin
        data_d = {data_q[STAGES-2:0], d};
        fill_d = {fill_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      fill_q <= '0;
    end else begin
      data_q <= data_d;
      fill_q <= fill_d;
    end
  end

  assign q     = data_q[STAGES-1];
  assign valid = fill_q[STAGES-1];
endmodule

// File: rtl/clkout_relock.sv
module clkout_relock #(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic waiting
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = hold || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (hold)
      cnt_d = CW'(LOCK_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign waiting = (cnt_q != '0);
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
  import clkout_pkg::*;
(
  input  logic src_clk,
  input  logic rst_n,
  input  logic cfg_pd_mode,
  input  logic cfg_sync,
  input  logic pin_raw,
  input  logic pin_s,
  input  logic pin_s_valid,
  input  logic lock_wait,
  output logic clk_out,
  output logic pad_oe,
  output logic standby_req
);
  pin_fn_e fn;
  logic    is_pd;

  logic    hold_q, hold_d;
  logic    run_q, run_d;
  logic    en_async, en_sync;
  logic    sb_async, sb_sync;

  assign fn    = pin_fn_e'(cfg_pd_mode);
  assign is_pd = (fn == PIN_POWERDOWN);

  // commit point for synchronous mode: falling edge, clock low
  always_comb begin
    hold_d = pin_s_valid ? pin_s : hold_q;
    run_d  = pin_s_valid & pin_s & ~lock_wait;
  end

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      run_q  <= run_d;
    end
  end

  always_comb begin
    en_async = rst_n & pin_raw & ~lock_wait;
    sb_async = rst_n & is_pd & ~pin_raw;
    en_sync  = run_q;
    sb_sync  = is_pd & ~hold_q;
  end

  assign pad_oe      = cfg_sync ? en_sync : en_async;
  assign standby_req = cfg_sync ? sb_sync : sb_async;
  assign clk_out     = src_clk & pad_oe;
endmodule

// File: rtl/clkout_ctl.sv
module clkout_ctl #(
  parameter int LOCK_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic ctl_pin,
  input  logic cfg_pd_mode,
  input  logic cfg_sync,
  output logic clk_out,
  output logic pad_oe,
  output logic standby_req,
  output logic relock_busy
);
  logic pin_s;
  logic pin_s_valid;
  logic lock_wait;
  logic sb_int;

  clkout_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d     (ctl_pin),
    .q     (pin_s),
    .valid (pin_s_valid)
  );

  clkout_relock #(.LOCK_CYCLES(LOCK_CYCLES)) u_relock (
    .clk     (src_clk),
    .rst_n   (rst_n),
    .hold    (sb_int),
    .waiting (lock_wait)
  );

  clkout_gate u_gate (
    .src_clk     (src_clk),
    .rst_n       (rst_n),
    .cfg_pd_mode (cfg_pd_mode),
    .cfg_sync    (cfg_sync),
    .pin_raw     (ctl_pin),
    .pin_s       (pin_s),
    .pin_s_valid (pin_s_valid),
    .lock_wait   (lock_wait),
    .clk_out     (clk_out),
    .pad_oe      (pad_oe),
    .standby_req (sb_int)
  );

  assign standby_req = sb_int;
  assign relock_busy = lock_wait & ~sb_int;
endmodule

// File: rtl/clkout_ctl_chk.sv
module clkout_ctl_chk #(
  parameter int LOCK_CYCLES = 1024
) (
  input logic src_clk,
  input logic rst_n,
  input logic cfg_pd_mode,
  input logic cfg_sync,
  input logic clk_out,
  input logic pad_oe,
  input logic standby_req,
  input logic relock_busy
);
  localparam int RW = $clog2(LOCK_CYCLES + 2) + 1;

  logic [RW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (!relock_busy)
      run_d = '0;
    else if (run_q <= RW'(LOCK_CYCLES))
      run_d = run_q + RW'(1);
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else
      run_q <= run_d;
  end

  a_r2_enable_fn_no_standby: assert property (@(posedge src_clk) disable iff (!rst_n)
    !cfg_pd_mode |-> (!standby_req && !relock_busy));

  a_r3_standby_pad_off: assert property (@(posedge src_clk) disable iff (!rst_n)
    standby_req |-> !pad_oe);

  a_r8_relock_pad_off: assert property (@(posedge src_clk) disable iff (!rst_n)
    relock_busy |-> !pad_oe);

  a_r8_relock_bounded: assert property (@(posedge src_clk) disable iff (!rst_n)
    run_q <= RW'(LOCK_CYCLES));

  always_comb begin
    if (!pad_oe)
      a_r4_off_is_low: assert (!clk_out) else $error("clock high with pad released");
  end

  always @(pad_oe) begin
    if (rst_n && cfg_sync)
      a_r7_sync_change_low: assert (!src_clk) else $error("sync enable moved in high phase");
  end
endmodule

bind clkout_ctl clkout_ctl_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .src_clk     (src_clk),
  .rst_n       (rst_n),
  .cfg_pd_mode (cfg_pd_mode),
  .cfg_sync    (cfg_sync),
  .clk_out     (clk_out),
  .pad_oe      (pad_oe),
  .standby_req (standby_req),
  .relock_busy (relock_busy)
);

// File: tb/sim_clkout_ctl.sv
`timescale 1ns/1ps
module sim_clkout_ctl;
  localparam int LOCK = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1;
  logic pd_mode = 1'b0;
  logic sync_mode = 1'b0;
  logic clk_out, pad_oe, standby_req, relock_busy;

  int total = 0;
  int bad = 0;
  bit mon_on = 1'b0;
  int pw_bad = 0;
  int edge_bad = 0;
  realtime t_rise = 0.0;

  always #2.5 clk = ~clk;

  clkout_ctl #(.LOCK_CYCLES(LOCK)) u0 (
    .src_clk(clk), .rst_n(rst_n), .ctl_pin(pin), .cfg_pd_mode(pd_mode),
    .cfg_sync(sync_mode), .clk_out(clk_out), .pad_oe(pad_oe),
    .standby_req(standby_req), .relock_busy(relock_busy)
  );

  // R7 monitors: full pulses and enable changes only in the low phase
  always @(posedge clk_out) t_rise = $realtime;
  always @(negedge clk_out)
    if (mon_on && sync_mode && (($realtime - t_rise) < 2.49 || ($realtime - t_rise) > 2.51))
      pw_bad++;
  always @(pad_oe)
    if (mon_on && sync_mode && clk) edge_bad++;

  function automatic logic exp_standby(logic pd, logic p);
    return pd & ~p;
  endfunction

  function automatic logic exp_pad_enable_fn(logic p);
    return p;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $realtime);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $realtime);
    end
  endtask

  task automatic do_reset(logic pd, logic sy, logic p);
    mon_on = 1'b0;
    rst_n = 1'b0;
    pd_mode = pd;
    sync_mode = sy;
    pin = p;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 clk_out", clk_out, 1'b0);
    chk("R1 pad_oe", pad_oe, 1'b0);
    chk("R1 standby", standby_req, 1'b0);
    chk("R1 relock", relock_busy, 1'b0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  task automatic measure_relock(output int n);
    n = 0;
    @(negedge clk);
    #0.5;
    while (relock_busy && n < 4 * LOCK) begin
      n++;
      if (pad_oe !== 1'b0) chk("R8 pad off during relock", pad_oe, 1'b0);
      @(negedge clk);
      #0.5;
    end
  endtask

  initial begin : main
    int n;
    void'($urandom(32'h5eed_c10c));

    // async, enable function
    do_reset(1'b0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    #1;
    chk("R2 running clk_out", clk_out, 1'b1);
    chk("R4 running pad_oe", pad_oe, 1'b1);
    pin = 1'b0;
    #0.2;
    chk("R5 async cut clk_out", clk_out, 1'b0);
    chk("R5 async cut pad_oe", pad_oe, 1'b0);
    chk("R2 no standby", standby_req, 1'b0);
    pin = 1'b1;
    #0.2;
    chk("R5 async partial pulse", clk_out, 1'b1);
    chk("R2 no relock", relock_busy, 1'b0);

    // async, power-down function
    do_reset(1'b1, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    #1 pin = 1'b0;
    #0.2;
    chk("R3 standby", standby_req, 1'b1);
    chk("R3 pad off", pad_oe, 1'b0);
    chk("R4 clk low", clk_out, 1'b0);
    repeat (3) @(posedge clk);
    #1 pin = 1'b1;
    #0.2;
    chk("R5 standby drop", standby_req, 1'b0);
    chk("R8 relock start", relock_busy, 1'b1);
    measure_relock(n);
    chk_int("R8 async relock length", n, LOCK);
    chk("R8 async resumes", pad_oe, 1'b1);

    // sync, enable function
    do_reset(1'b0, 1'b1, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1 pin = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    chk("R6 sync still on", pad_oe, 1'b1);
    chk("R6 sync full high", clk_out, 1'b1);
    @(negedge clk);
    #0.5;
    chk("R6 sync off at fall", pad_oe, 1'b0);
    @(negedge clk);
    #1 pin = 1'b1;
    @(posedge clk); @(posedge clk);
    #1;
    chk("R7 sync not yet on", pad_oe, 1'b0);
    @(negedge clk);
    #0.5;
    chk("R7 sync on at fall", pad_oe, 1'b1);
    chk("R7 low phase", clk_out, 1'b0);
    @(posedge clk);
    #0.5;
    chk("R7 first pulse", clk_out, 1'b1);
    chk("R2 sync no relock", relock_busy, 1'b0);

    // sync, power-down function
    do_reset(1'b1, 1'b1, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1 pin = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    chk("R9 standby not yet", standby_req, 1'b0);
    chk("R6 pd still on", pad_oe, 1'b1);
    @(negedge clk);
    #0.5;
    chk("R9 standby at fall", standby_req, 1'b1);
    chk("R9 pad off same fall", pad_oe, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 pin = 1'b1;
    @(posedge clk); @(posedge clk);
    #1;
    chk("R6 standby held", standby_req, 1'b1);
    measure_relock(n);
    chk_int("R8 sync relock length", n, LOCK);
    chk("R8 sync resumes", pad_oe, 1'b1);

    // random phase over all four configurations
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic pd = cfg[0];
      logic sy = cfg[1];
      do_reset(pd, sy, 1'(($urandom() >> 3) & 1));
      for (int i = 0; i < 30; i++) begin
        repeat ($urandom_range(1, 20)) @(posedge clk);
        #(1 + $urandom_range(0, 3));
        pin = ~pin;
        #0.2;
        if (!sy) begin
          chk("R3 rand standby", standby_req, exp_standby(pd, pin));
          if (!pd) chk("R2 rand pad", pad_oe, exp_pad_enable_fn(pin));
          else if (!pin) chk("R4 rand pad off", pad_oe, 1'b0);
        end
      end
      pin = 1'b1;
      repeat (LOCK + 10) @(posedge clk);
      #1;
      chk("R8 rand settle pad", pad_oe, 1'b1);
      chk("R8 rand settle standby", standby_req, 1'b0);
      chk("R8 rand settle relock", relock_busy, 1'b0);
    end
    mon_on = 1'b0;
    chk_int("R7 pulse widths", pw_bad, 0);
    chk_int("R7 enable in low phase", edge_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule